// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is one DMA channel that follows a chain of 32-byte descriptors held in memory. Software places the first descriptor's link word, byte count, source address, destination address and configuration word into the channel through a small write port. The configuration word goes last, and its enable bit starts the channel. The channel then moves the data in beats: each beat reads one word at the source and writes it at the destination. When the count reaches zero, the channel either stops or reads the next descriptor over the same read port and continues.

A descriptor can ask for a node-complete pulse when it finishes. A descriptor whose link word has the chain flag clear ends the chain with a chain-complete pulse. If the last link points back to the first descriptor, the chain runs as an endless ring, and the node pulses mark period boundaries. Clearing the enable bit pauses the channel without losing its position. The live remaining count and the active link word are always visible, so software can compute the residue.

Top module: `lldma_channel`

## Requirements
- R1: After reset, busy, curCount, curLink, memRdReq, memWrEn, nodeDone and chainDone are all zero.
- R2: A register write takes regSel codes 0 = link word, 1 = byte count, 2 = source address, 3 = destination address, 4 = config, and the other codes do nothing. A config write with bit 0 set, made while idle, raises busy at the second rising edge after the write is presented.
- R3: Each beat is a read request at the source address, followed in the next cycle by a write at the destination address of the returned word. The beat size in bytes is 2 to the power of config bits 13:12, capped at the bus width of 4 bytes. The final beat shrinks to the bytes that remain, and memWrStrb enables the low lanes equal to the beat size.
- R4: The source address advances by the beat size after each beat only when config bit 31 is set. The destination address does the same only when config bit 30 is set.
- R5: curCount shows the remaining byte count of the active descriptor and falls by the beat size with every beat.
- R6: To load a descriptor, the channel reads eight words in order, starting at the link word with its low 5 bits cleared. It keeps word 0 as the link, word 4 as the count, word 5 as the source, word 6 as the destination and word 7 as the config. Words 1 to 3 have no effect.
- R7: A descriptor whose link word has bit 1 clear (a zero link included) ends the chain when its count is exhausted. chainDone pulses for one cycle, busy drops in the next cycle, and the enable bit clears.
- R8: When a descriptor with config bit 1 set finishes, nodeDone pulses for one cycle.
- R9: A ring whose last link points back to its first descriptor repeats without end, and chainDone never fires.
- R10: Clearing config bit 0 while the channel is busy stops new memory reads and keeps busy, count, addresses and link unchanged. Setting it again resumes, and the total number of beats stays the same.
- R11: curLink shows the link word most recently loaded, either by software or by a descriptor fetch.
- R12: A descriptor with a zero count finishes with no beats and still gives its node and chain pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 3 | Register select code |
| regWdata | input | 32 | Register write data |
| memRdReq | output | 1 | Memory read request |
| memRdAddr | output | ADDR_W (32) | Memory read byte address |
| memRdData | input | DATA_W (32) | Read data, valid the cycle after the request |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | ADDR_W (32) | Memory write byte address |
| memWrData | output | DATA_W (32) | Memory write data |
| memWrStrb | output | DATA_W/8 (4) | Byte lane enables for the write |
| busy | output | 1 | Channel is active or paused mid-chain |
| curCount | output | CNT_W (16) | Remaining bytes of the active descriptor |
| curLink | output | 32 | Link word of the active descriptor |
| nodeDone | output | 1 | Node-complete pulse |
| chainDone | output | 1 | Chain-complete pulse |

## Verification
The single-descriptor table covers every beat width, including the capped width code 3. It also covers counts that leave a short final beat, each increment bit alone and both together, and a zero count. This separates errors in beat sizing, strobe generation, address stepping and node signalling. A three-descriptor chain with junk in its reserved words checks that fetched fields land in the right registers and that the reserved words have no effect. A two-node ring that is paused in the middle of a fetch and then resumed checks that chainDone stays silent, that the pause holds across a descriptor reload, and that curLink tracks the loaded link. A long single transfer paused mid-stream checks that the live count and the beat total are kept.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

  localparam int unsigned DESC_WORDS = 8;
  localparam int unsigned DESC_IDX_W = $clog2(DESC_WORDS);

  // software register select codes
  localparam logic [2:0] SEL_LINK = 3'd0;
  localparam logic [2:0] SEL_CNT  = 3'd1;
  localparam logic [2:0] SEL_SRC  = 3'd2;
  localparam logic [2:0] SEL_DST  = 3'd3;
  localparam logic [2:0] SEL_CFG  = 3'd4;

  // descriptor word slots
  localparam logic [DESC_IDX_W-1:0] W_LINK = DESC_IDX_W'(0);
  localparam logic [DESC_IDX_W-1:0] W_CNT  = DESC_IDX_W'(4);
  localparam logic [DESC_IDX_W-1:0] W_SRC  = DESC_IDX_W'(5);
  localparam logic [DESC_IDX_W-1:0] W_DST  = DESC_IDX_W'(6);
  localparam logic [DESC_IDX_W-1:0] W_CFG  = DESC_IDX_W'(7);

  // config and link bit positions
  localparam int unsigned CFG_EN     = 0;
  localparam int unsigned CFG_NODE   = 1;
  localparam int unsigned CFG_WIDTH  = 12;
  localparam int unsigned CFG_DSTINC = 30;
  localparam int unsigned CFG_SRCINC = 31;
  localparam int unsigned LINK_CHAIN = 1;
  localparam int unsigned LINK_ALIGN = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WRITE, ST_NODE, ST_FREQ, ST_FCAP
  } ctrlState_t;

  typedef struct packed {
    logic                  issueRd;
    logic                  doWr;
    logic                  issueFetch;
    logic                  capFetch;
    logic [DESC_IDX_W-1:0] wordIdx;
    logic                  nodeStart;
    logic                  clrEn;
  } dpStrobe_t;

  typedef struct packed {
    logic enable;
    logic cntZero;
    logic lastBeat;
    logic chainOn;
    logic nodeIrq;
  } dpStatus_t;

endpackage

// File: rtl/lldma_ctrl.sv
module lldma_ctrl
  import lldma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpStatus_t stat,
  output dpStrobe_t strb,
  output logic      busy,
  output logic      nodeDone,
  output logic      chainDone
);

  localparam logic [DESC_IDX_W-1:0] LAST_IDX = DESC_IDX_W'(DESC_WORDS - 1);

  ctrlState_t state, nextState;
  logic [DESC_IDX_W-1:0] wordIdx;

  always_comb begin
    strb         = '0;
    strb.wordIdx = wordIdx;
    nextState    = state;
    nodeDone     = 1'b0;
    chainDone    = 1'b0;
    unique case (state)
      ST_IDLE:  if (stat.enable) nextState = ST_READ;
      ST_READ: begin
        if (stat.cntZero) nextState = ST_NODE;
        else if (stat.enable) begin
          strb.issueRd = 1'b1;
          nextState    = ST_WRITE;
        end
      end
      ST_WRITE: begin
        strb.doWr = 1'b1;
        nextState = stat.lastBeat ? ST_NODE : ST_READ;
      end
      ST_NODE: begin
        nodeDone = stat.nodeIrq;
        if (stat.chainOn) begin
          strb.nodeStart = 1'b1;
          nextState      = ST_FREQ;
        end else begin
          chainDone  = 1'b1;
          strb.clrEn = 1'b1;
          nextState  = ST_IDLE;
        end
      end
      ST_FREQ: begin
        if (stat.enable) begin
          strb.issueFetch = 1'b1;
          nextState       = ST_FCAP;
        end
      end
      ST_FCAP: begin
        strb.capFetch = 1'b1;
        nextState     = (wordIdx == LAST_IDX) ? ST_READ : ST_FREQ;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
    end else begin
      state <= nextState;
      if (state == ST_NODE) wordIdx <= '0;
      else if (state == ST_FCAP)
        wordIdx <= (wordIdx == LAST_IDX) ? '0 : wordIdx + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

  assert_chain_end_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    chainDone |=> !busy);
  assert_chain_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    chainDone |=> !chainDone);
  assert_fetch_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.issueFetch |=> strb.capFetch && (strb.wordIdx == $past(strb.wordIdx)));

endmodule

// File: rtl/lldma_datapath.sv
module lldma_datapath
  import lldma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [2:0]          regSel,
  input  logic [31:0]         regWdata,
  input  dpStrobe_t           strb,
  output dpStatus_t           stat,
  output logic [ADDR_W-1:0]   memRdAddr,
  input  logic [DATA_W-1:0]   memRdData,
  output logic [ADDR_W-1:0]   memWrAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic [DATA_W/8-1:0] memWrStrb,
  output logic [CNT_W-1:0]    curCount,
  output logic [31:0]         curLink
);

  localparam int unsigned LANES    = DATA_W / 8;
  localparam int unsigned LANE_LOG = $clog2(LANES);
  localparam logic [1:0]  MAX_LOG  = 2'(LANE_LOG);

  logic [31:0]       linkReg;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] srcAddr, dstAddr, fetchBase;
  logic              cfgEn, cfgNode, cfgSrcInc, cfgDstInc;
  logic [1:0]        cfgWidth;

  logic [1:0]        sizeLog;
  logic [CNT_W-1:0]  widthBytes, beat;
  logic [31:0]       descWord;
  logic              capLink, capCnt, capSrc, capDst, capCfg;
  logic              swLink, swCnt, swSrc, swDst, swCfg;

  assign sizeLog    = (cfgWidth > MAX_LOG) ? MAX_LOG : cfgWidth;
  assign widthBytes = CNT_W'(1) << sizeLog;
  assign beat       = (cnt < widthBytes) ? cnt : widthBytes;
  assign descWord   = memRdData[31:0];

  assign capLink = strb.capFetch && (strb.wordIdx == W_LINK);
  assign capCnt  = strb.capFetch && (strb.wordIdx == W_CNT);
  assign capSrc  = strb.capFetch && (strb.wordIdx == W_SRC);
  assign capDst  = strb.capFetch && (strb.wordIdx == W_DST);
  assign capCfg  = strb.capFetch && (strb.wordIdx == W_CFG);
  assign swLink  = regWr && (regSel == SEL_LINK);
  assign swCnt   = regWr && (regSel == SEL_CNT);
  assign swSrc   = regWr && (regSel == SEL_SRC);
  assign swDst   = regWr && (regSel == SEL_DST);
  assign swCfg   = regWr && (regSel == SEL_CFG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkReg   <= '0;
      cnt       <= '0;
      srcAddr   <= '0;
      dstAddr   <= '0;
      fetchBase <= '0;
      cfgEn     <= 1'b0;
      cfgNode   <= 1'b0;
      cfgSrcInc <= 1'b0;
      cfgDstInc <= 1'b0;
      cfgWidth  <= '0;
    end else begin
      if (capLink)     linkReg <= descWord;
      else if (swLink) linkReg <= regWdata;

      if (strb.doWr)  cnt <= cnt - beat;
      else if (capCnt) cnt <= descWord[CNT_W-1:0];
      else if (swCnt)  cnt <= regWdata[CNT_W-1:0];

      if (strb.doWr && cfgSrcInc) srcAddr <= srcAddr + ADDR_W'(beat);
      else if (capSrc)            srcAddr <= ADDR_W'(descWord);
      else if (swSrc)             srcAddr <= ADDR_W'(regWdata);

      if (strb.doWr && cfgDstInc) dstAddr <= dstAddr + ADDR_W'(beat);
      else if (capDst)            dstAddr <= ADDR_W'(descWord);
      else if (swDst)             dstAddr <= ADDR_W'(regWdata);

      if (strb.nodeStart)
        fetchBase <= ADDR_W'({linkReg[31:LINK_ALIGN], LINK_ALIGN'(0)});

      if (capCfg) begin
        // a pause written during the fetch survives the config reload
        cfgEn     <= swCfg ? regWdata[CFG_EN] : (descWord[CFG_EN] & cfgEn);
        cfgNode   <= descWord[CFG_NODE];
        cfgSrcInc <= descWord[CFG_SRCINC];
        cfgDstInc <= descWord[CFG_DSTINC];
        cfgWidth  <= descWord[CFG_WIDTH +: 2];
      end else if (swCfg) begin
        cfgEn     <= regWdata[CFG_EN];
        cfgNode   <= regWdata[CFG_NODE];
        cfgSrcInc <= regWdata[CFG_SRCINC];
        cfgDstInc <= regWdata[CFG_DSTINC];
        cfgWidth  <= regWdata[CFG_WIDTH +: 2];
      end else if (strb.clrEn) begin
        cfgEn <= 1'b0;
      end
    end
  end

  assign memRdAddr = strb.issueFetch
                   ? fetchBase + ADDR_W'({strb.wordIdx, 2'b00})
                   : srcAddr;
  assign memWrAddr = dstAddr;
  assign memWrData = memRdData;

  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    assign memWrStrb[lane] = CNT_W'(lane) < beat;
  end

  assign stat.enable   = cfgEn;
  assign stat.cntZero  = (cnt == '0);
  assign stat.lastBeat = (cnt == beat);
  assign stat.chainOn  = linkReg[LINK_CHAIN];
  assign stat.nodeIrq  = cfgNode;

  assign curCount = cnt;
  assign curLink  = linkReg;

  assert_count_falls_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.doWr |=> cnt < $past(cnt));
  assert_single_access_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.issueRd, strb.issueFetch, strb.doWr}));
  assert_beat_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.doWr |-> (memWrStrb != '0) && (beat <= cnt));
  assert_pause_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEn && !strb.doWr && !strb.capFetch && !regWr)
      |=> $stable(cnt) && $stable(srcAddr) && $stable(dstAddr) && $stable(linkReg));

endmodule

// File: rtl/lldma_channel.sv
module lldma_channel
  import lldma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [2:0]          regSel,
  input  logic [31:0]         regWdata,
  output logic                memRdReq,
  output logic [ADDR_W-1:0]   memRdAddr,
  input  logic [DATA_W-1:0]   memRdData,
  output logic                memWrEn,
  output logic [ADDR_W-1:0]   memWrAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic [DATA_W/8-1:0] memWrStrb,
  output logic                busy,
  output logic [CNT_W-1:0]    curCount,
  output logic [31:0]         curLink,
  output logic                nodeDone,
  output logic                chainDone
);

  dpStrobe_t strb;
  dpStatus_t stat;

  lldma_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .stat      (stat),
    .strb      (strb),
    .busy      (busy),
    .nodeDone  (nodeDone),
    .chainDone (chainDone)
  );

  lldma_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regSel    (regSel),
    .regWdata  (regWdata),
    .strb      (strb),
    .stat      (stat),
    .memRdAddr (memRdAddr),
    .memRdData (memRdData),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData),
    .memWrStrb (memWrStrb),
    .curCount  (curCount),
    .curLink   (curLink)
  );

  assign memRdReq = strb.issueRd | strb.issueFetch;
  assign memWrEn  = strb.doWr;

endmodule

// File: tb/lldma_channel_bench.sv
`timescale 1ns/1ps
module lldma_channel_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regSel = '0;
  logic [31:0] regWdata = '0;
  logic        memRdReq, memWrEn, busy, nodeDone, chainDone;
  logic [31:0] memRdAddr, memWrAddr, memWrData, curLink;
  logic [31:0] rdDataQ = '0;
  logic [3:0]  memWrStrb;
  logic [15:0] curCount;

  always #4 clk = ~clk;

  lldma_channel u_lldma_channel (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWdata(regWdata),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdData(rdDataQ),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memWrStrb(memWrStrb), .busy(busy), .curCount(curCount), .curLink(curLink),
    .nodeDone(nodeDone), .chainDone(chainDone)
  );

  // memory model and activity monitor
  logic [31:0] mem [256];
  int wrCnt = 0, rdCnt = 0, nodeCnt = 0, chainCnt = 0;
  logic [31:0] lastWrAddr = '0, lastWrData = '0;
  logic [3:0]  lastWrStrb = '0;

  always @(posedge clk) begin
    if (memRdReq) rdDataQ <= mem[memRdAddr[9:2]];
    if (memWrEn) begin
      for (int b = 0; b < 4; b++)
        if (memWrStrb[b]) mem[memWrAddr[9:2]][8*b +: 8] <= memWrData[8*b +: 8];
    end
    if (rstN) begin
      if (memWrEn) begin
        wrCnt <= wrCnt + 1; lastWrAddr <= memWrAddr;
        lastWrData <= memWrData; lastWrStrb <= memWrStrb;
      end
      if (memRdReq)  rdCnt <= rdCnt + 1;
      if (nodeDone)  nodeCnt <= nodeCnt + 1;
      if (chainDone) chainCnt <= chainCnt + 1;
    end
  end

  int compared = 0, mismatched = 0;

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller stands at a negedge; returns at the following negedge
  task automatic regWrite(input logic [2:0] sel, input logic [31:0] data);
    regWr = 1'b1; regSel = sel; regWdata = data;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic loadHead(input logic [31:0] link, input logic [31:0] count,
                          input logic [31:0] src, input logic [31:0] dst, input logic [31:0] cfg);
    regWrite(3'd0, link);
    regWrite(3'd1, count);
    regWrite(3'd2, src);
    regWrite(3'd3, dst);
    regWrite(3'd4, cfg);
  endtask

  task automatic waitChain(input int base, input string req);
    int n = 0;
    while (chainCnt == base && n < 3000) begin @(negedge clk); n++; end
    checkEq({req, " chain finished"}, 32'(chainCnt - base), 32'd1);
  endtask

  function automatic logic [31:0] mkCfg(input logic si, input logic di,
                                        input logic [1:0] w, input logic irq, input logic en);
    return {si, di, 16'd0, w, 10'd0, irq, en};
  endfunction

  typedef struct packed {
    logic [15:0] count;
    logic [1:0]  width;
    logic        srcInc;
    logic        dstInc;
    logic        nodeIrq;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{16'd16, 2'd2, 1'b1, 1'b1, 1'b1},
    '{16'd7,  2'd2, 1'b1, 1'b1, 1'b0},
    '{16'd5,  2'd0, 1'b1, 1'b0, 1'b1},
    '{16'd6,  2'd1, 1'b0, 1'b1, 1'b0},
    '{16'd8,  2'd3, 1'b1, 1'b1, 1'b0},
    '{16'd0,  2'd2, 1'b1, 1'b1, 1'b1}
  };

  task automatic runVector(input vec_t v);
    int bytes, beats, lastLen, w0, n0, c0;
    logic [31:0] expSrc, expDst;
    bytes = 1 << ((v.width > 2'd2) ? 2 : int'(v.width));
    beats = (int'(v.count) + bytes - 1) / bytes;
    lastLen = int'(v.count) - (beats - 1) * bytes;
    expSrc = 32'h100 + (v.srcInc ? 32'((beats - 1) * bytes) : 32'd0);
    expDst = 32'h180 + (v.dstInc ? 32'((beats - 1) * bytes) : 32'd0);
    w0 = wrCnt; n0 = nodeCnt; c0 = chainCnt;
    loadHead(32'h0, 32'(v.count), 32'h100, 32'h180,
             mkCfg(v.srcInc, v.dstInc, v.width, v.nodeIrq, 1'b1));
    waitChain(c0, "R7");
    checkEq("R3 beat count", 32'(wrCnt - w0), 32'(beats));
    if (beats > 0) begin
      checkEq("R3 last strobe", 32'(lastWrStrb), 32'((1 << lastLen) - 1));
      checkEq("R4 last dest address", lastWrAddr, expDst);
      checkEq("R4 last data from source", lastWrData, mem[expSrc[9:2]]);
    end else begin
      checkEq("R12 zero count no beats", 32'(wrCnt - w0), 32'd0);
    end
    checkEq("R8 node pulse", 32'(nodeCnt - n0), 32'(v.nodeIrq));
    checkEq("R7 busy dropped", 32'(busy), 32'd0);
    checkEq("R5 count exhausted", 32'(curCount), 32'd0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 ^ (32'(i) * 32'h0103_0507);
    doReset();

    // R1 reset state
    checkEq("R1 busy", 32'(busy), 32'd0);
    checkEq("R1 curCount", 32'(curCount), 32'd0);
    checkEq("R1 curLink", curLink, 32'd0);
    checkEq("R1 no traffic", {30'd0, memRdReq, memWrEn}, 32'd0);
    checkEq("R1 no pulses", {30'd0, nodeDone, chainDone}, 32'd0);

    // R3 R4 R5 R8 R12 table of single-descriptor transfers
    for (int v = 0; v < NVEC; v++) runVector(VECS[v]);

    // R2 start latency and unused select code, then a three-node chain (R6 R7 R11)
    begin
      int w0, r0, n0, c0;
      mem[144] = 32'h282; mem[145] = 32'hDEAD_BEEF; mem[146] = 32'hDEAD_BEEF; mem[147] = 32'hDEAD_BEEF;
      mem[148] = 32'd4; mem[149] = 32'h110; mem[150] = 32'h1C0; mem[151] = mkCfg(1, 1, 2'd2, 1, 1);
      mem[160] = 32'h0; mem[161] = 32'hFFFF_FFFF; mem[162] = 32'hFFFF_FFFF; mem[163] = 32'hFFFF_FFFF;
      mem[164] = 32'd12; mem[165] = 32'h120; mem[166] = 32'h1D0; mem[167] = mkCfg(1, 1, 2'd2, 0, 1);
      w0 = wrCnt; r0 = rdCnt; n0 = nodeCnt; c0 = chainCnt;
      regWrite(3'd0, 32'h242);
      regWrite(3'd1, 32'd8);
      regWrite(3'd2, 32'h100);
      regWrite(3'd3, 32'h180);
      regWrite(3'd6, 32'hFFFF_FFFF);
      checkEq("R2 unused select leaves link", curLink, 32'h242);
      regWrite(3'd4, mkCfg(1, 1, 2'd2, 0, 1));
      checkEq("R2 busy low after first edge", 32'(busy), 32'd0);
      @(negedge clk);
      checkEq("R2 busy high after second edge", 32'(busy), 32'd1);
      waitChain(c0, "R7");
      checkEq("R6 total beats ignore reserved words", 32'(wrCnt - w0), 32'd6);
      checkEq("R6 reads incl two fetches", 32'(rdCnt - r0), 32'd22);
      checkEq("R8 one node pulse in chain", 32'(nodeCnt - n0), 32'd1);
      checkEq("R6 second node data", mem[112], mem[68]);
      checkEq("R6 third node last data", mem[118], mem[74]);
      checkEq("R11 link of final node", curLink, 32'h0);
    end

    // R10 R5 pause and resume in mid transfer
    begin
      int w0, c0, wp;
      logic [15:0] cp;
      w0 = wrCnt; c0 = chainCnt;
      loadHead(32'h0, 32'd40, 32'h100, 32'h180, mkCfg(1, 1, 2'd2, 0, 1));
      repeat (7) @(negedge clk);
      regWrite(3'd4, mkCfg(1, 1, 2'd2, 0, 0));
      repeat (3) @(negedge clk);
      wp = wrCnt; cp = curCount;
      checkEq("R5 live count while paused", 32'(cp), 32'(40 - 4 * (wp - w0)));
      repeat (20) @(negedge clk);
      checkEq("R10 no beats while paused", 32'(wrCnt), 32'(wp));
      checkEq("R10 count held", 32'(curCount), 32'(cp));
      checkEq("R10 busy held", 32'(busy), 32'd1);
      regWrite(3'd4, mkCfg(1, 1, 2'd2, 0, 1));
      waitChain(c0, "R10");
      checkEq("R10 beat total after resume", 32'(wrCnt - w0), 32'd10);
      checkEq("R10 last word copied", mem[105], mem[73]);
    end

    // R9 R11 R10 cyclic ring paused inside a descriptor fetch
    begin
      int n0, c0, r0, k;
      mem[192] = 32'h322; mem[196] = 32'd4; mem[197] = 32'h100; mem[198] = 32'h1E0;
      mem[199] = mkCfg(1, 1, 2'd2, 0, 1);
      mem[200] = 32'h302; mem[204] = 32'd4; mem[205] = 32'h104; mem[206] = 32'h1E4;
      mem[207] = mkCfg(1, 1, 2'd2, 1, 1);
      n0 = nodeCnt; c0 = chainCnt;
      loadHead(32'h322, 32'd4, 32'h100, 32'h1E0, mkCfg(1, 1, 2'd2, 0, 1));
      k = 0;
      while (nodeCnt < n0 + 3 && k < 3000) begin @(negedge clk); k++; end
      checkEq("R9 ring reached third period", 32'(nodeCnt - n0), 32'd3);
      regWrite(3'd4, mkCfg(1, 1, 2'd2, 0, 0));
      repeat (2) @(negedge clk);
      r0 = rdCnt;
      repeat (20) @(negedge clk);
      checkEq("R10 fetch held by pause", 32'(rdCnt), 32'(r0));
      checkEq("R11 link loaded by fetch", curLink, 32'h322);
      checkEq("R10 busy while paused in fetch", 32'(busy), 32'd1);
      regWrite(3'd4, mkCfg(1, 1, 2'd2, 0, 1));
      k = 0;
      while (nodeCnt < n0 + 5 && k < 3000) begin @(negedge clk); k++; end
      checkEq("R9 ring keeps cycling", 32'(nodeCnt - n0), 32'd5);
      checkEq("R9 no chain completion", 32'(chainCnt - c0), 32'd0);
      doReset();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule